// File: doc/BRIEF.md
# High-Speed Burst Framing Sequencer

This block frames one transmit burst for a lane whose symbols are later 8b/10b coded and serialized. It emits one token per symbol clock: a kind code plus a byte. The downstream encoder and driver use the kind to decide how the symbol goes on the wire: a negative or positive line level, a coded data symbol, a marker, a filler, or the run-length-violation tail. Between bursts the line rests in a save state driven negative for as long as needed.

A burst request taken in the save state starts a fixed sequence. First comes a prepare period at the positive level. Next is a synchronization run of data symbols, which can be short (0 to 15 symbols) or extended (24 plus a 4-bit count). One start marker follows, and then the payload. Payload bytes arrive on a valid/ready stream. The stream is ready only while the payload phase runs. A byte is accepted on any clock edge where both valid and ready are high, and it appears as a token on the next cycle. If valid is low while ready is high, a filler token takes that symbol slot, so back-pressure never stalls the symbol clock. Once the byte flagged as last is accepted, the block sends the tail symbols and returns to the save state.

Top module: `burst_frame_seq`

## Requirements
- R1: Each token is registered, and tok_valid is high on every cycle after reset. During reset and in the save state, tok_kind is 0 (negative level), tok_byte is 0 and in_ready is low.
- R2: burst_req is sampled only in the save state. A request made during a burst has no effect.
- R3: The cycle after a request is accepted, the prepare phase emits exactly prep_len+1 tokens of kind 1 (positive level), each with byte 0.
- R4: The sync phase emits tokens of kind 2 with byte SYNC_BYTE (default 0xB5). There are sync_cnt of them when sync_ext is 0, and SYNC_BASE+sync_cnt (default 24+sync_cnt) when sync_ext is 1. A length of zero skips the phase.
- R5: After sync comes exactly one token of kind 3 (start marker, byte 0), and the payload phase begins on the next cycle.
- R6: in_ready is high only during the payload phase. An accepted byte is emitted on the next cycle with kind 4 (data), or with kind 5 (marker) when in_mark is set, and with tok_byte equal to the byte.
- R7: In any payload cycle where in_valid is low, a filler token of kind 6 with byte 0 is emitted.
- R8: Accepting a byte with in_last set ends the payload. The block then emits TAIL_SYMS (default 2) tokens of kind 7 with byte 0, goes back to kind 0, and in_ready stays low.
- R9: prep_len, sync_ext and sync_cnt are latched when the request is accepted. Changing them during a burst does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_req | input | 1 | Start a burst (sampled in save state) |
| prep_len | input | PREP_W | Prepare length minus one |
| sync_ext | input | 1 | Select extended sync length |
| sync_cnt | input | SYNC_CNT_W | Sync count |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | DATA_W | Payload byte |
| in_mark | input | 1 | Send this byte as a marker |
| in_last | input | 1 | Final payload byte |
| in_ready | output | 1 | Payload byte accepted when valid |
| tok_valid | output | 1 | Token valid |
| tok_kind | output | 3 | Token kind code |
| tok_byte | output | DATA_W | Token byte |

## Verification
The assertions check the local properties on every cycle. They confirm that each accepted byte reappears as the next token and that an empty payload slot becomes filler. They also confirm that the kinds follow the legal order: save, then prepare, then sync, then marker, then payload, then tail, then save. A sync token always carries the sync byte, and the stream is ready right after the start marker. Only the bench scenarios can show the counted lengths of the prepare and sync phases in both length modes, the exact number of tail symbols, and the latching of the configuration. They also show that a request raised during a burst is ignored, which needs whole bursts to be compared against an expected token list.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef enum logic [2:0] {
    TK_NEG  = 3'd0,
    TK_POS  = 3'd1,
    TK_SYNC = 3'd2,
    TK_MK0  = 3'd3,
    TK_DATA = 3'd4,
    TK_MARK = 3'd5,
    TK_FLR  = 3'd6,
    TK_TAIL = 3'd7
  } tok_kind_e;

  typedef enum logic [2:0] {
    ST_SAVE,
    ST_PREP,
    ST_SYNC,
    ST_MK0,
    ST_PAY,
    ST_TAIL
  } seq_state_e;
endpackage

// File: rtl/bfs_cfg_latch.sv
module bfs_cfg_latch #(
  parameter int SYNC_CNT_W = 4,
  parameter int SYNC_BASE  = 24,
  parameter int SYNC_LEN_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  sync_ext,
  input  logic [SYNC_CNT_W-1:0] sync_cnt,
  output logic [SYNC_LEN_W-1:0] sync_len
);
  // sync length is resolved once, when the burst is accepted (R9)
  logic [SYNC_LEN_W-1:0] len_next;

  always_comb begin
    if (sync_ext) len_next = SYNC_LEN_W'(SYNC_BASE) + SYNC_LEN_W'(sync_cnt);
    else          len_next = SYNC_LEN_W'(sync_cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    sync_len <= '0;
    else if (load) sync_len <= len_next;
  end
endmodule

// File: rtl/bfs_ctrl.sv
module bfs_ctrl
  import bfs_pkg::*;
#(
  parameter int PREP_W     = 4,
  parameter int SYNC_LEN_W = 6,
  parameter int TAIL_SYMS  = 2,
  parameter int CNT_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  burst_req,
  input  logic [PREP_W-1:0]     prep_len,
  input  logic [SYNC_LEN_W-1:0] sync_len,
  input  logic                  in_valid,
  input  logic                  in_last,
  output seq_state_e            state,
  output logic                  start
);
  logic [CNT_W-1:0] cnt;

  assign start = (state == ST_SAVE) && burst_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_SAVE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_SAVE: if (burst_req) begin
          state <= ST_PREP;
          cnt   <= CNT_W'(prep_len);
        end
        ST_PREP: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (sync_len == '0) state <= ST_MK0;
          else begin
            state <= ST_SYNC;
            cnt   <= CNT_W'(sync_len) - CNT_W'(1);
          end
        end
        ST_SYNC: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else           state <= ST_MK0;
        end
        ST_MK0: state <= ST_PAY;
        ST_PAY: if (in_valid && in_last) begin
          state <= ST_TAIL;
          cnt   <= CNT_W'(TAIL_SYMS - 1);
        end
        ST_TAIL: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else           state <= ST_SAVE;
        end
        default: state <= ST_SAVE;
      endcase
    end
  end
endmodule

// File: rtl/bfs_tok_reg.sv
module bfs_tok_reg
  import bfs_pkg::*;
#(
  parameter int         DATA_W    = 8,
  parameter logic [7:0] SYNC_BYTE = 8'hB5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  logic              in_valid,
  input  logic              in_mark,
  input  logic [DATA_W-1:0] in_data,
  output logic              tok_valid,
  output tok_kind_e         tok_kind,
  output logic [DATA_W-1:0] tok_byte
);
  tok_kind_e         kind_d;
  logic [DATA_W-1:0] byte_d;

  always_comb begin
    kind_d = TK_NEG;
    byte_d = '0;
    unique case (state)
      ST_SAVE: kind_d = TK_NEG;
      ST_PREP: kind_d = TK_POS;
      ST_SYNC: begin
        kind_d = TK_SYNC;
        byte_d = DATA_W'(SYNC_BYTE);
      end
      ST_MK0:  kind_d = TK_MK0;
      ST_PAY: begin
        if (in_valid) begin
          kind_d = in_mark ? TK_MARK : TK_DATA;
          byte_d = in_data;
        end else begin
          kind_d = TK_FLR;
        end
      end
      ST_TAIL: kind_d = TK_TAIL;
      default: kind_d = TK_NEG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok_valid <= 1'b0;
      tok_kind  <= TK_NEG;
      tok_byte  <= '0;
    end else begin
      tok_valid <= 1'b1;
      tok_kind  <= kind_d;
      tok_byte  <= byte_d;
    end
  end
endmodule

// File: rtl/burst_frame_seq.sv
module burst_frame_seq
  import bfs_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter int         PREP_W     = 4,
  parameter int         SYNC_CNT_W = 4,
  parameter int         SYNC_BASE  = 24,
  parameter int         TAIL_SYMS  = 2,
  parameter logic [7:0] SYNC_BYTE  = 8'hB5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  burst_req,
  input  logic [PREP_W-1:0]     prep_len,
  input  logic                  sync_ext,
  input  logic [SYNC_CNT_W-1:0] sync_cnt,
  input  logic                  in_valid,
  input  logic [DATA_W-1:0]     in_data,
  input  logic                  in_mark,
  input  logic                  in_last,
  output logic                  in_ready,
  output logic                  tok_valid,
  output logic [2:0]            tok_kind,
  output logic [DATA_W-1:0]     tok_byte
);
  localparam int SYNC_LEN_W = $clog2(SYNC_BASE + (1 << SYNC_CNT_W));
  localparam int TAIL_W     = $clog2(TAIL_SYMS + 1);
  localparam int CNT_A      = (PREP_W > SYNC_LEN_W) ? PREP_W : SYNC_LEN_W;
  localparam int CNT_W      = (CNT_A > TAIL_W) ? CNT_A : TAIL_W;

  seq_state_e            state;
  logic                  start;
  logic [SYNC_LEN_W-1:0] sync_len;
  tok_kind_e             kind_q;

  bfs_cfg_latch #(
    .SYNC_CNT_W(SYNC_CNT_W), .SYNC_BASE(SYNC_BASE), .SYNC_LEN_W(SYNC_LEN_W)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .load(start),
    .sync_ext(sync_ext), .sync_cnt(sync_cnt), .sync_len(sync_len)
  );

  bfs_ctrl #(
    .PREP_W(PREP_W), .SYNC_LEN_W(SYNC_LEN_W), .TAIL_SYMS(TAIL_SYMS), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .burst_req(burst_req), .prep_len(prep_len),
    .sync_len(sync_len), .in_valid(in_valid), .in_last(in_last),
    .state(state), .start(start)
  );

  bfs_tok_reg #(.DATA_W(DATA_W), .SYNC_BYTE(SYNC_BYTE)) tok_i (
    .clk(clk), .rst_n(rst_n), .state(state), .in_valid(in_valid),
    .in_mark(in_mark), .in_data(in_data),
    .tok_valid(tok_valid), .tok_kind(kind_q), .tok_byte(tok_byte)
  );

  assign in_ready = (state == ST_PAY);
  assign tok_kind = kind_q;
endmodule

// File: rtl/bfs_checker.sv
module bfs_checker
  import bfs_pkg::*;
#(
  parameter int         DATA_W    = 8,
  parameter logic [7:0] SYNC_BYTE = 8'hB5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              in_ready,
  input logic [2:0]        tok_kind,
  input logic [DATA_W-1:0] tok_byte
);
  p_save_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tok_kind == TK_NEG |=> (tok_kind == TK_NEG || tok_kind == TK_POS));

  p_prep_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tok_kind == TK_POS |=> (tok_kind == TK_POS || tok_kind == TK_SYNC || tok_kind == TK_MK0));

  p_sync_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tok_kind == TK_SYNC |=> (tok_kind == TK_SYNC || tok_kind == TK_MK0));

  p_sync_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tok_kind == TK_SYNC |-> tok_byte == DATA_W'(SYNC_BYTE));

  p_mk0_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tok_kind == TK_MK0 |-> in_ready);

  p_accept_emit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=>
      ((tok_kind == TK_DATA || tok_kind == TK_MARK) && tok_byte == $past(in_data)));

  p_fill_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> tok_kind == TK_FLR);

  p_tail_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tok_kind == TK_TAIL |=> (tok_kind == TK_TAIL || tok_kind == TK_NEG));
endmodule

bind burst_frame_seq bfs_checker #(.DATA_W(DATA_W), .SYNC_BYTE(SYNC_BYTE)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .tok_kind(tok_kind), .tok_byte(tok_byte)
);

// File: tb/burst_frame_seq_tb_top.sv
module burst_frame_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TAILN = 2;
  localparam logic [7:0] SYNCB = 8'hB5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_req = 1'b0;
  logic [3:0] prep_len = '0;
  logic sync_ext = 1'b0;
  logic [3:0] sync_cnt = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_mark = 1'b0;
  logic in_last = 1'b0;
  logic in_ready, tok_valid;
  logic [2:0] tok_kind;
  logic [7:0] tok_byte;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [10:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_frame_seq dut_i (
    .clk(clk), .rst_n(rst_n), .burst_req(burst_req), .prep_len(prep_len),
    .sync_ext(sync_ext), .sync_cnt(sync_cnt), .in_valid(in_valid),
    .in_data(in_data), .in_mark(in_mark), .in_last(in_last),
    .in_ready(in_ready), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .tok_byte(tok_byte)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string kind_tag(input logic [2:0] k);
    case (k)
      3'd1: return "R3 prepare";
      3'd2: return "R4 sync";
      3'd3: return "R5 marker";
      3'd4, 3'd5: return "R6 payload";
      3'd6: return "R7 filler";
      3'd7: return "R8 tail";
      default: return "R1 level";
    endcase
  endfunction

  task automatic push(input logic [2:0] k, input logic [7:0] b);
    expq.push_back({k, b});
  endtask

  // monitor: pop and compare every non-idle token
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tok_valid && tok_kind != 3'd0) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R2 unexpected token kind", int'(tok_kind), 0);
        end else begin
          logic [10:0] e;
          e = expq.pop_front();
          chk({tok_kind, tok_byte} == e, kind_tag(e[10:8]),
              int'({tok_kind, tok_byte}), int'(e));
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_burst(input int prep, input bit ext, input int scnt, input int nbytes,
                           input logic [15:0] gaps, input int mark_idx, input bit disturb);
    int slen, pre, idx, pc;
    bit all_low;
    slen = ext ? 24 + scnt : scnt;
    pre = prep + 1 + slen + 1;
    @(negedge clk);
    prep_len = 4'(prep); sync_ext = ext; sync_cnt = 4'(scnt); burst_req = 1'b1;
    for (int i = 0; i <= prep; i++) push(3'd1, 8'h00);
    for (int i = 0; i < slen; i++) push(3'd2, SYNCB);
    push(3'd3, 8'h00);
    all_low = 1'b1;
    for (int k = 1; k <= pre; k++) begin
      @(negedge clk);
      burst_req = 1'b0;
      if (disturb) begin
        // R9: change the configuration, R2: re-request mid-burst
        prep_len = 4'd15; sync_ext = ~ext; sync_cnt = 4'd9;
        if (k == 2) burst_req = 1'b1;
      end
      if (in_ready) all_low = 1'b0;
    end
    chk(all_low, "R6 ready low before payload", 0, 0);
    @(negedge clk);
    burst_req = 1'b0;
    chk(in_ready == 1'b1, "R5 payload opens after marker", int'(in_ready), 1);
    idx = 0; pc = 0;
    while (idx < nbytes) begin
      if (disturb && pc == 1) burst_req = 1'b1; else burst_req = 1'b0;
      if (pc < 16 && gaps[pc]) begin
        in_valid = 1'b0; in_last = 1'b0; in_mark = 1'b0;
        push(3'd6, 8'h00);
      end else begin
        in_valid = 1'b1;
        in_data = 8'(8'h30 + idx * 7);
        in_mark = (idx == mark_idx);
        in_last = (idx == nbytes - 1);
        push(in_mark ? 3'd5 : 3'd4, in_data);
        if (in_last) for (int t = 0; t < TAILN; t++) push(3'd7, 8'h00);
        idx++;
      end
      pc++;
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0; in_mark = 1'b0; burst_req = 1'b0;
    chk(in_ready == 1'b0, "R8 ready drops after last", int'(in_ready), 0);
    repeat (TAILN + 1) @(negedge clk);
    chk(tok_kind == 3'd0, "R8 back to save level", int'(tok_kind), 0);
    chk(in_ready == 1'b0, "R8 ready stays low", int'(in_ready), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tok_valid == 1'b0 && tok_kind == 3'd0, "R1 reset token", int'(tok_kind), 0);
    chk(in_ready == 1'b0, "R1 reset ready", int'(in_ready), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tok_valid == 1'b1, "R1 valid every cycle", int'(tok_valid), 1);
    chk(tok_kind == 3'd0 && tok_byte == 8'h00, "R1 save level", int'(tok_kind), 0);

    run_burst(2, 1'b0, 3, 4, 16'h0000, -1, 1'b0);   // short sync, back-to-back data
    run_burst(0, 1'b1, 2, 5, 16'b0000_0000_0010_0101, 3, 1'b1); // extended sync, gaps, marker, disturbance
    run_burst(5, 1'b0, 0, 1, 16'h0002, -1, 1'b0);   // zero sync, single byte
    run_burst(0, 1'b1, 15, 2, 16'h0000, 0, 1'b0);   // longest sync

    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R2 no leftover expected tokens", expq.size(), 0);
    chk(tok_kind == 3'd0, "R1 idle after bursts", int'(tok_kind), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule